// File: doc/BRIEF.md
# Center-Aligned Triangle-Count PWM Generator

This block turns a programmable period and a programmable compare level into a symmetric, center-aligned pulse train. An internal counter climbs from zero to the period value and then walks back down to zero, forming a triangle of 2×P clocks. The counter is checked against the active compare level on every clock. A hit on the rising slope sets the output and a hit on the falling slope clears it, so the high time is centred on the counter peak.

Period and compare are written through their input ports, which act as shadow copies. The active period is refreshed only when the counter is at zero. The active compare is refreshed either at zero or at the peak, chosen by a select pin. A full cycle therefore never runs on a mixture of old and new settings. While the enable pin is low, the block parks with the counter at zero, counting upward, and the output low. Single-clock flags mark the trough and the peak, and a direction pin reports the slope.

The pins carry control and status only. There is no streamed data, so no valid/ready handshake and no back-pressure applies.

Top module: `pwm_tri_gen`

## Requirements
- R1: With enable high and active period P ≥ 1, a cycle begins at the clock where the counter is 0 (position t=0) and lasts 2P clocks. `dir_up` reads 1 for positions 0..P-1 and 0 for positions P..2P-1. At the peak the direction already reads 0, and at the trough it already reads 1.
- R2: A compare hit (counter equals the active compare) while `dir_up` is 1 drives `pwm_out` high on the next clock.
- R3: A compare hit while `dir_up` is 0 drives `pwm_out` low on the next clock. Without a hit, `pwm_out` keeps its value.
- R4: In steady state with constant compare C ≤ P, `pwm_out` is high at position t exactly when C < t' ≤ 2P−C, where t' = 2P if t = 0 and t' = t otherwise. For P = 4, compares 4, 3, 2, 1 and 0 give 0, 2, 4, 6 and 8 high clocks out of 8.
- R5: With `load_sel` = 0, a new `cmp_in` is taken on the clock edge where the counter is 0. It governs hits from position 1 of that cycle onward.
- R6: With `load_sel` = 1, a new `cmp_in` is taken on the clock edge where the counter equals the period. It governs hits from position P+1 onward.
- R7: A new `period_in` takes effect only at the next position 0. The cycle in progress keeps its old peak.
- R8: While `en` is low, the next clock shows counter 0, `dir_up` = 1, `pwm_out` = 0, and both flags low. When `en` rises, that same clock is position 0.
- R9: `at_zero` is high exactly at position 0 and `at_prd` exactly at position P, each for one clock and never both at once.
- R10: At the turning points, compare = P is a falling-slope hit (0% duty) and compare = 0 is a rising-slope hit (100% duty). A single clock never both sets and clears the output.
- R11: After reset, the outputs read `pwm_out` = 0 and `dir_up` = 1, and with `en` low both flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low parks the block |
| period_in | input | CNT_W | Shadow period (peak count) |
| cmp_in | input | CNT_W | Shadow compare level |
| load_sel | input | 1 | Compare load point: 0 = at zero, 1 = at peak |
| pwm_out | output | 1 | Center-aligned PWM output |
| dir_up | output | 1 | 1 while counting up |
| at_zero | output | 1 | One-clock flag at counter zero |
| at_prd | output | 1 | One-clock flag at counter peak |

## Verification
The main function is swept over every compare level from 0 to P for each period from 1 to 6. Each output is checked at every position of two steady cycles, so an off-by-one in the set or clear point, or in which slope owns the turning point, shows up as a wrong duty. Compare changes made mid-cycle under each load-point setting tell loading at zero apart from loading at the peak, because the falling half of the cycle follows different levels in the two cases. A period change made mid-cycle shows whether the old peak is kept, and an enable drop shows the parked state and a clean restart.

// File: rtl/pwm_tri_pkg.sv
package pwm_tri_pkg;
  typedef enum logic {
    LD_AT_ZERO = 1'b0,
    LD_AT_PEAK = 1'b1
  } ld_pt_e;
endpackage

// File: rtl/tri_counter.sv
module tri_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] prd_shadow,
  output logic [CNT_W-1:0] cnt,
  output logic             up,
  output logic [CNT_W-1:0] prd_act,
  output logic             zero_evt,
  output logic             peak_evt
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] eff_prd, n_cnt;
  logic             n_up;

  // the active period is refreshed only at the trough
  assign eff_prd = (cnt == ZERO) ? prd_shadow : prd_act;

  always_comb begin
    n_cnt = ZERO;
    n_up  = 1'b1;
    if (en && eff_prd != ZERO) begin
      if (up) begin
        n_cnt = cnt + 1'b1;
        n_up  = (n_cnt != eff_prd);
      end else begin
        n_cnt = cnt - 1'b1;
        n_up  = (n_cnt == ZERO);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= ZERO;
      up      <= 1'b1;
      prd_act <= ZERO;
    end else begin
      cnt     <= n_cnt;
      up      <= n_up;
      prd_act <= eff_prd;
    end
  end

  assign zero_evt = en && (cnt == ZERO);
  assign peak_evt = en && (prd_act != ZERO) && (cnt == prd_act);
endmodule

// File: rtl/cmp_shadow.sv
module cmp_shadow
  import pwm_tri_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  ld_pt_e           ld_pt,
  input  logic             zero_evt,
  input  logic             peak_evt,
  input  logic [CNT_W-1:0] cmp_shadow,
  output logic [CNT_W-1:0] cmp_act
);
  logic load_now;

  assign load_now = !en || ((ld_pt == LD_AT_ZERO) ? zero_evt : peak_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cmp_act <= '0;
    else if (load_now) cmp_act <= cmp_shadow;
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] cnt,
  input  logic             up,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             pwm
);
  logic hit;

  assign hit = en && (cnt == cmp_act);

  // a hit takes the slope in force on that clock: set when rising, clear when falling
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pwm <= 1'b0;
    else if (!en) pwm <= 1'b0;
    else if (hit) pwm <= up;
  end
endmodule

// File: rtl/pwm_tri_gen.sv
module pwm_tri_gen
  import pwm_tri_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             load_sel,
  output logic             pwm_out,
  output logic             dir_up,
  output logic             at_zero,
  output logic             at_prd
);
  logic [CNT_W-1:0] cnt_q, prd_act, cmp_act;
  ld_pt_e           ld_pt;

  assign ld_pt = ld_pt_e'(load_sel);

  tri_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en), .prd_shadow(period_in),
    .cnt(cnt_q), .up(dir_up), .prd_act(prd_act),
    .zero_evt(at_zero), .peak_evt(at_prd)
  );

  cmp_shadow #(.CNT_W(CNT_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .en(en), .ld_pt(ld_pt),
    .zero_evt(at_zero), .peak_evt(at_prd),
    .cmp_shadow(cmp_in), .cmp_act(cmp_act)
  );

  pwm_action #(.CNT_W(CNT_W)) u_act (
    .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt_q), .up(dir_up),
    .cmp_act(cmp_act), .pwm(pwm_out)
  );
endmodule

// File: rtl/pwm_tri_gen_chk.sv
module pwm_tri_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_act,
  input logic             up,
  input logic             pwm,
  input logic             at_zero,
  input logic             at_prd
);
  p_set_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm) |-> $past(en && (cnt == cmp_act) && up));

  p_clear_on_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm) |-> $past(!en || ((cnt == cmp_act) && !up)));

  p_park_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((cnt == '0) && up && !pwm));

  p_flags_apart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_zero && at_prd));

  p_peak_is_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    at_prd |-> !up);

  p_trough_is_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
    at_zero |-> up);

  p_unit_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != '0) |=> ((cnt == CNT_W'($past(cnt) + 1'b1)) ||
                           (cnt == CNT_W'($past(cnt) - 1'b1))));
endmodule

bind pwm_tri_gen pwm_tri_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .cnt(cnt_q), .cmp_act(cmp_act),
  .up(dir_up), .pwm(pwm_out), .at_zero(at_zero), .at_prd(at_prd)
);

// File: tb/pwm_tri_gen_test.sv
`timescale 1ns/1ps
module pwm_tri_gen_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] period_in = '0;
  logic [W-1:0] cmp_in = '0;
  logic         load_sel = 1'b0;
  logic         pwm_out, dir_up, at_zero, at_prd;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwm_tri_gen #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .period_in(period_in),
    .cmp_in(cmp_in), .load_sel(load_sel), .pwm_out(pwm_out),
    .dir_up(dir_up), .at_zero(at_zero), .at_prd(at_prd)
  );

  function automatic bit exp_pwm(int t, int c, int p);
    int tp = (t == 0) ? 2 * p : t;
    return (tp > c) && (tp <= 2 * p - c);
  endfunction

  task automatic chk(bit got, bit exp, string req, string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // check flags and direction for position t of a cycle with peak p
  task automatic chk_shape(int t, int p);
    chk(dir_up, t < p, "R1", "dir_up");
    chk(at_zero, t == 0, "R9", "at_zero");
    chk(at_prd, t == p, "R9", "at_prd");
  endtask

  // park, load shadows, enable; returns at position 0 (a negedge)
  task automatic start(int p, int c, bit sel);
    en = 1'b0; period_in = W'(p); cmp_in = W'(c); load_sel = sel;
    @(negedge clk);
    en = 1'b1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(pwm_out, 1'b0, "R11", "pwm after reset");
    chk(dir_up, 1'b1, "R11", "dir after reset");
    chk(at_zero, 1'b0, "R11", "at_zero after reset");
    chk(at_prd, 1'b0, "R11", "at_prd after reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: every period 1..6, every compare 0..P, two steady cycles checked
    for (int p = 1; p <= 6; p++) begin
      for (int c = 0; c <= p; c++) begin
        start(p, c, 1'b0);
        for (int k = 0; k < 4 * p; k++) begin
          #1;
          if (k >= 2 * p) begin
            chk_shape(k % (2 * p), p);
            if (c == 0 || c == p)
              chk(pwm_out, exp_pwm(k % (2 * p), c, p), "R10", "turning-point duty");
            else if (p == 4)
              chk(pwm_out, exp_pwm(k % (2 * p), c, p), "R4", "duty step");
            else
              chk(pwm_out, exp_pwm(k % (2 * p), c, p), "R2 R3", "set/clear");
          end
          @(negedge clk);
        end
      end
    end

    // compare loaded at zero: change at position 1 of cycle 1
    start(4, 2, 1'b0);
    for (int k = 0; k < 24; k++) begin
      #1;
      if (k == 9) cmp_in = W'(1);
      if (k >= 9)
        chk(pwm_out, exp_pwm(k % 8, (k <= 16) ? 2 : 1, 4), "R5", "zero-load pwm");
      @(negedge clk);
    end

    // compare loaded at peak
    start(4, 2, 1'b1);
    for (int k = 0; k < 24; k++) begin
      #1;
      if (k == 9) cmp_in = W'(1);
      if (k >= 9)
        chk(pwm_out, exp_pwm(k % 8, (k <= 12) ? 2 : 1, 4), "R6", "peak-load pwm");
      @(negedge clk);
    end

    // period shadow: 4 -> 3 requested mid-cycle
    start(4, 2, 1'b0);
    for (int k = 0; k < 23; k++) begin
      #1;
      if (k == 9) period_in = W'(3);
      if (k >= 9) begin
        chk(at_prd, (k == 12) || (k == 19), "R7", "peak position");
        chk(at_zero, (k == 16) || (k == 22), "R7", "trough position");
        chk(dir_up, (k < 12) || (k >= 16 && k < 19) || (k == 22), "R7", "direction");
      end
      @(negedge clk);
    end

    // enable drop mid-cycle, then restart
    start(4, 2, 1'b0);
    repeat (5) @(negedge clk);
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(pwm_out, 1'b0, "R8", "parked pwm");
      chk(dir_up, 1'b1, "R8", "parked dir");
      chk(at_zero, 1'b0, "R8", "parked at_zero");
      chk(at_prd, 1'b0, "R8", "parked at_prd");
    end
    @(negedge clk);
    en = 1'b1;
    for (int k = 0; k < 8; k++) begin
      #1;
      chk_shape(k, 4);
      chk(pwm_out, exp_pwm(k, 2, 4), "R8", "restart pwm");
      @(negedge clk);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule